// File: doc/BRIEF.md
# Sixteen-Bit Hierarchical Lookahead Adder

This block adds two unsigned 16-bit operands and a carry input. It returns a 16-bit sum and a carry output. The operands are split into four 4-bit slices. Each slice forms its internal carries in parallel from per-bit generate and propagate terms. Each slice also reports a group generate and a group propagate for the whole slice.

A second-level lookahead stage applies the same parallel expansion to the four group pairs and the external carry input. It produces every slice carry-in and the final carry-out at once, so no carry ripples from slice to slice.

The result and carry-out are captured in output registers clocked by `clk`. They appear one cycle after the operands are presented. A synchronous active-high reset clears those registers.

Top module: `cla_adder`

## Requirements
- R1: One clock edge after operands `a_in`, `b_in` and `c_in` are sampled with reset low, `sum_q` equals bits [15:0] of `a_in + b_in + c_in`.
- R2: At that same edge, `cout_q` equals bit 16 of `a_in + b_in + c_in`, the carry out of the most significant bit.
- R3: A slice whose four bit pairs all propagate (exactly one of each `a`/`b` bit pair is 1) hands its carry-in straight to the next slice. For example, 0xFFFF + 0x0000 with `c_in`=1 gives sum 0x0000 and carry-out 1.
- R4: A slice that generates a carry does so whatever its carry-in. For example, 0x000F + 0x0001 with `c_in`=0 gives 0x0010.
- R5: The carry into each slice boundary (bits 4, 8 and 12) and the carry out of bit 15 are correct for any operands. For example, 0x00FF + 0x0001 gives 0x0100, and 0x0FFF + 0x0001 gives 0x1000.
- R6: When `rst` is high at a rising edge of `clk`, `sum_q` and `cout_q` become 0 at that edge, whatever the operand values.
- R7: With both operands zero and `c_in`=1, the result is 0x0001 with carry-out 0.
- R8: The outputs are registered. A change on the operands does not show on `sum_q` or `cout_q` until the next rising edge of `clk`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; outputs update on the rising edge |
| rst | input | 1 | Synchronous active-high reset of the output registers |
| a_in | input | 16 | First operand |
| b_in | input | 16 | Second operand |
| c_in | input | 1 | Carry input into bit 0 |
| sum_q | output | 16 | Registered 16-bit sum |
| cout_q | output | 1 | Registered carry out of bit 15 |

## Verification
Two of the block's functions can coincide in one cycle: a carry generated inside a low slice, and whole-slice propagation across every higher slice. The bench provokes this with operands such as 0xFFF8 + 0x0008 and 0xFFFF + 0x0000 with carry-in set. In those cases a carry born in one slice, or entering at bit 0, must reach the carry-out through the second-level stage in one pass. Each case is judged by comparing the registered {carry, sum} with integer addition one edge later. A reset applied while such operands are present must still force zeros.

// File: rtl/cla_pkg.sv
package cla_pkg;
  localparam int unsigned CLA_DATA_W  = 16;
  localparam int unsigned CLA_SLICE_W = 4;
endpackage

// File: rtl/cla_lookahead.sv
module cla_lookahead #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] gen_i,
  input  logic [W-1:0] prop_i,
  input  logic         cin_i,
  output logic [W:0]   carry_o,
  output logic         grp_gen_o,
  output logic         grp_prop_o
);
  // Parallel sum-of-products carries: each carry built only from gen, prop and cin.
  always_comb begin
    logic acc;
    logic term;
    carry_o[0] = cin_i;
    for (int k = 0; k < W; k++) begin
      term = cin_i;
      for (int m = 0; m <= k; m++) term = term & prop_i[m];
      acc = term;
      for (int j = 0; j <= k; j++) begin
        term = gen_i[j];
        for (int m = j + 1; m <= k; m++) term = term & prop_i[m];
        acc = acc | term;
      end
      carry_o[k+1] = acc;
    end
  end

  always_comb begin
    logic gg;
    logic t;
    gg = 1'b0;
    for (int j = 0; j < W; j++) begin
      t = gen_i[j];
      for (int m = j + 1; m < W; m++) t = t & prop_i[m];
      gg = gg | t;
    end
    grp_gen_o  = gg;
    grp_prop_o = &prop_i;
  end

  // Independent ripple formulation used only to guard the expanded carries.
  logic [W:0] ripple;
  always_comb begin
    ripple[0] = cin_i;
    for (int k = 0; k < W; k++) ripple[k+1] = gen_i[k] | (prop_i[k] & ripple[k]);
  end

  always_comb begin
    if (!$isunknown({gen_i, prop_i, cin_i})) begin
      a_r5_expansion_matches_ripple: assert (carry_o == ripple)
        else $error("R5 lookahead carries disagree with ripple form");
    end
  end
endmodule

// File: rtl/cla_slice.sv
module cla_slice #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         grp_gen_o,
  output logic         grp_prop_o
);
  logic [W-1:0] bit_gen;
  logic [W-1:0] bit_prop;
  logic [W:0]   carry;

  assign bit_gen  = a_i & b_i;
  assign bit_prop = a_i ^ b_i;

  cla_lookahead #(.W(W)) u_la (
    .gen_i      (bit_gen),
    .prop_i     (bit_prop),
    .cin_i      (cin_i),
    .carry_o    (carry),
    .grp_gen_o  (grp_gen_o),
    .grp_prop_o (grp_prop_o)
  );

  assign sum_o = bit_prop ^ carry[W-1:0];

  always_comb begin
    if (!$isunknown({a_i, b_i, cin_i})) begin
      a_r4_group_gen_forces_carry: assert (!grp_gen_o || carry[W])
        else $error("R4 slice generates but carry out is low");
      a_r3_group_prop_passes_cin: assert (!grp_prop_o || (carry[W] == cin_i))
        else $error("R3 slice propagates but carry out differs from carry in");
    end
  end
endmodule

// File: rtl/cla_adder.sv
module cla_adder
  import cla_pkg::*;
#(
  parameter int unsigned DATA_W  = CLA_DATA_W,
  parameter int unsigned SLICE_W = CLA_SLICE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] a_in,
  input  logic [DATA_W-1:0] b_in,
  input  logic              c_in,
  output logic [DATA_W-1:0] sum_q,
  output logic              cout_q
);
  localparam int unsigned N_SLICES = DATA_W / SLICE_W;

  logic [N_SLICES-1:0] slice_gen;
  logic [N_SLICES-1:0] slice_prop;
  logic [N_SLICES:0]   slice_carry;
  logic [DATA_W-1:0]   sum_d;
  logic                top_gen;
  logic                top_prop;

  for (genvar s = 0; s < N_SLICES; s++) begin : g_slice
    cla_slice #(.W(SLICE_W)) u_slice (
      .a_i        (a_in[s*SLICE_W +: SLICE_W]),
      .b_i        (b_in[s*SLICE_W +: SLICE_W]),
      .cin_i      (slice_carry[s]),
      .sum_o      (sum_d[s*SLICE_W +: SLICE_W]),
      .grp_gen_o  (slice_gen[s]),
      .grp_prop_o (slice_prop[s])
    );
  end

  // Second-level stage: same expansion over the slice group signals.
  cla_lookahead #(.W(N_SLICES)) u_group (
    .gen_i      (slice_gen),
    .prop_i     (slice_prop),
    .cin_i      (c_in),
    .carry_o    (slice_carry),
    .grp_gen_o  (top_gen),
    .grp_prop_o (top_prop)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q  <= '0;
      cout_q <= 1'b0;
    end else begin
      sum_q  <= sum_d;
      cout_q <= slice_carry[N_SLICES];
    end
  end

  always_comb begin
    if (!$isunknown({a_in, b_in, c_in})) begin
      a_r2_top_gen_sets_cout: assert (!top_gen || slice_carry[N_SLICES])
        else $error("R2 group generate without carry out");
      a_r3_top_prop_passes_cin: assert (!top_prop || (slice_carry[N_SLICES] == c_in))
        else $error("R3 full propagate but carry out differs from carry in");
    end
  end

  a_r1_registered_sum: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ({cout_q, sum_q} == ({1'b0, $past(a_in)} + {1'b0, $past(b_in)}
                                  + {{DATA_W{1'b0}}, $past(c_in)})))
    else $error("R1 registered result differs from integer sum");

  a_r6_reset_clears: assert property (@(posedge clk)
    rst |=> (sum_q == '0 && !cout_q))
    else $error("R6 reset did not clear outputs");
endmodule

// File: tb/cla_adder_tb.sv
`timescale 1ns/1ps
module cla_adder_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] a_in = '0;
  logic [15:0] b_in = '0;
  logic        c_in = 1'b0;
  logic [15:0] sum_q;
  logic        cout_q;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  cla_adder u_dut (
    .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in), .c_in(c_in),
    .sum_q(sum_q), .cout_q(cout_q)
  );

  // Each entry: {c_in, b, a}
  localparam int NV = 12;
  localparam logic [32:0] VEC [0:NV-1] = '{
    {1'b1, 16'h0000, 16'hFFFF},
    {1'b0, 16'h0001, 16'h000F},
    {1'b0, 16'h0001, 16'h00FF},
    {1'b0, 16'h0001, 16'h0FFF},
    {1'b1, 16'h0000, 16'h0000},
    {1'b0, 16'h0008, 16'hFFF8},
    {1'b1, 16'hFFFF, 16'hFFFF},
    {1'b0, 16'h5555, 16'hAAAA},
    {1'b1, 16'h5555, 16'hAAAA},
    {1'b0, 16'hAAAA, 16'hAAAA},
    {1'b1, 16'h0F0F, 16'hF0F0},
    {1'b0, 16'h8000, 16'h8000}
  };

  task automatic check(input string req, input logic [16:0] got, input logic [16:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic run_add(input string req, input logic [15:0] a, input logic [15:0] b, input logic ci);
    logic [16:0] exp;
    @(negedge clk);
    a_in = a; b_in = b; c_in = ci;
    exp = {1'b0, a} + {1'b0, b} + {16'h0, ci};
    @(negedge clk);
    check(req, {cout_q, sum_q}, exp);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    check("R6 reset state", {cout_q, sum_q}, 17'h0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      run_add("R1 R2 R3 R4 R5 R7 vector table",
              VEC[i][15:0], VEC[i][31:16], VEC[i][32]);
    end

    run_add("R3 full propagate with carry in", 16'hFFFF, 16'h0000, 1'b1);
    run_add("R4 slice generate", 16'h000F, 16'h0001, 1'b0);
    run_add("R5 boundary 8", 16'h00FF, 16'h0001, 1'b0);
    run_add("R5 boundary 12", 16'h0FFF, 16'h0001, 1'b0);
    run_add("R7 carry in alone", 16'h0000, 16'h0000, 1'b1);

    // R8: operand change is invisible until next rising edge
    @(negedge clk);
    a_in = 16'h1234; b_in = 16'h1111; c_in = 1'b0;
    @(negedge clk);
    a_in = 16'h0F00; b_in = 16'h0100; c_in = 1'b1;
    #1;
    check("R8 output holds until edge", {cout_q, sum_q}, 17'h02345);
    @(negedge clk);
    check("R8 output after edge", {cout_q, sum_q}, 17'h01001);

    // R6: reset overrides carry-heavy operands
    @(negedge clk);
    a_in = 16'hFFFF; b_in = 16'hFFFF; c_in = 1'b1; rst = 1'b1;
    @(negedge clk);
    check("R6 reset with operands", {cout_q, sum_q}, 17'h0);
    rst = 1'b0;

    for (int i = 0; i < 1000; i++) begin
      run_add("R1 R2 random", 16'($urandom), 16'($urandom), 1'($urandom));
    end

    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog got=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule